// File: doc/BRIEF.md
# Memory-Mapped Console Port

This block is a console device on a processor's load/store bus. It has two independent halves. The receive half takes characters from a keyboard-side source and holds the most recent one. The transmit half sends characters that software writes to a display-side sink. Software reaches the block through four word-wide registers above a fixed base address. It either polls a ready flag in each half or lets that half raise an interrupt request.

The bus is a simple single-cycle port. During a cycle with `bus_rd` high, `bus_rdata` carries the selected register, decoded combinationally from `bus_addr`. A write takes effect at the rising clock edge that ends the cycle with `bus_wr` high. Side effects of a read, such as clearing the receive flag, also happen at that edge.

Neither stream port has back-pressure. Every cycle with `kbd_valid` high delivers a character, which the block always accepts. `tx_valid` is a single-cycle pulse that the sink must take without stalling. Pacing on the transmit side comes only from the programmable busy time. During that time the transmit ready flag is low, and further characters written by software are dropped.

Top module: `mmio_console`

## Requirements
- R1: After reset, the receive ready flag is 0, the transmit ready flag is 1, both interrupt enables are 0, both interrupt requests are 0 and `tx_valid` is 0.
- R2: The registers are decoded at `BASE_ADDR` (default 0xFFFF0000) plus these offsets: 0x0 receive control, 0x4 receive data, 0x8 transmit control, 0xC transmit data. A read of any other address returns 0, and a write to any other address changes nothing.
- R3: In both control registers, bit 0 is the ready flag (read-only) and bit 1 is the interrupt enable (read/write). All other bits read 0, and writes to them are ignored.
- R4: A cycle with `kbd_valid` high stores `kbd_data` and sets the receive ready flag from the next cycle onward. The receive data register reads the stored byte in bits 7:0 and zeros above.
- R5: Reading the receive data register clears the receive ready flag from the next cycle onward. The stored byte does not change.
- R6: A character that arrives while the receive ready flag is 1 replaces the stored byte, and the flag stays 1. If a character arrives in the same cycle as a read of receive data, the read returns the old byte, the new byte is stored and the flag ends at 1.
- R7: The receive data register is read-only. A write to it leaves the stored byte unchanged.
- R8: `irq_rx` is high exactly when the receive interrupt enable and the receive ready flag are both 1.
- R9: A write to transmit data while the transmit ready flag is 1 drives `tx_valid` high for exactly one cycle, on the cycle after the write, with `tx_data` equal to bits 7:0 of the written word. The ready flag is 0 from that same cycle.
- R10: After an accepted character, the transmit ready flag stays 0 for exactly `TX_BUSY_CYCLES` cycles and then returns to 1.
- R11: A write to transmit data while the transmit ready flag is 0 produces no `tx_valid` pulse and does not move the time at which the flag returns to 1.
- R12: `irq_tx` is high exactly when the transmit interrupt enable and the transmit ready flag are both 1.
- R13: `bus_rdata` is 0 in every cycle with `bus_rd` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_rd | input | 1 | Read strobe for this cycle |
| bus_wr | input | 1 | Write strobe for this cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid while `bus_rd` is high |
| kbd_valid | input | 1 | A character is offered this cycle (always accepted) |
| kbd_data | input | CHAR_W | Offered character |
| tx_valid | output | 1 | One-cycle pulse carrying an outgoing character |
| tx_data | output | CHAR_W | Outgoing character |
| irq_rx | output | 1 | Receive interrupt request (level 0) |
| irq_tx | output | 1 | Transmit interrupt request (level 1) |

## Verification
Two pairs of events can fall in the same cycle.

The first pair is an incoming keyboard character and a software read of receive data. The bench drives `kbd_valid` and the read strobe in one cycle. It then judges three things: the returned value must be the previous byte, and on the following cycles the control register must show ready still set and the data register must hold the new byte.

The second pair is a transmit write that lands while the busy interval is still running. The bench checks that no pulse appears and that the ready flag still returns on the cycle counted from the first accepted write.

// File: rtl/con_pkg.sv
package con_pkg;
  localparam int unsigned REG_CNT   = 4;
  localparam int unsigned REG_STEP  = 4;
  localparam int unsigned RDY_BIT   = 0;
  localparam int unsigned IE_BIT    = 1;

  typedef enum logic [1:0] {
    REG_RX_CTRL = 2'd0,
    REG_RX_DATA = 2'd1,
    REG_TX_CTRL = 2'd2,
    REG_TX_DATA = 2'd3
  } con_reg_e;
endpackage

// File: rtl/con_bus_decode.sv
module con_bus_decode
  import con_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_0000
) (
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_rd,
  input  logic               bus_wr,
  output logic [REG_CNT-1:0] rd_sel,
  output logic [REG_CNT-1:0] wr_sel
);
  logic [REG_CNT-1:0] hit;

  for (genvar g = 0; g < REG_CNT; g++) begin : g_reg
    localparam logic [ADDR_W-1:0] REG_ADDR = BASE_ADDR + ADDR_W'(g * REG_STEP);
    assign hit[g]    = (bus_addr == REG_ADDR);
    assign rd_sel[g] = hit[g] & bus_rd;
    assign wr_sel[g] = hit[g] & bus_wr;
  end
endmodule

// File: rtl/con_rx_unit.sv
module con_rx_unit #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [CHAR_W-1:0] in_data,
  input  logic              data_rd,
  input  logic              ctrl_wr,
  input  logic              ie_wdata,
  output logic              rdy,
  output logic              ie,
  output logic [CHAR_W-1:0] held,
  output logic              irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy  <= 1'b0;
      ie   <= 1'b0;
      held <= '0;
    end else begin
      // a new arrival takes priority over the clearing read
      if (in_valid) begin
        held <= in_data;
        rdy  <= 1'b1;
      end else if (data_rd) begin
        rdy  <= 1'b0;
      end
      if (ctrl_wr) ie <= ie_wdata;
    end
  end

  assign irq = ie & rdy;
endmodule

// File: rtl/con_tx_unit.sv
module con_tx_unit #(
  parameter int unsigned CHAR_W      = 8,
  parameter int unsigned BUSY_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_wr,
  input  logic [CHAR_W-1:0] wdata,
  input  logic              ctrl_wr,
  input  logic              ie_wdata,
  output logic              rdy,
  output logic              ie,
  output logic              out_valid,
  output logic [CHAR_W-1:0] out_data,
  output logic              irq
);
  localparam int unsigned CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_CYCLES - 1);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy       <= 1'b1;
      ie        <= 1'b0;
      remain    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (ctrl_wr) ie <= ie_wdata;
      if (rdy) begin
        if (data_wr) begin
          out_valid <= 1'b1;
          out_data  <= wdata;
          rdy       <= 1'b0;
          remain    <= LOAD;
        end
      end else if (remain == '0) begin
        rdy <= 1'b1;
      end else begin
        remain <= remain - 1'b1;
      end
    end
  end

  assign irq = ie & rdy;
endmodule

// File: rtl/mmio_console.sv
module mmio_console
  import con_pkg::*;
#(
  parameter int unsigned ADDR_W         = 32,
  parameter int unsigned DATA_W         = 32,
  parameter int unsigned CHAR_W         = 8,
  parameter int unsigned TX_BUSY_CYCLES = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              kbd_valid,
  input  logic [CHAR_W-1:0] kbd_data,
  output logic              tx_valid,
  output logic [CHAR_W-1:0] tx_data,
  output logic              irq_rx,
  output logic              irq_tx
);
  logic [REG_CNT-1:0] rd_sel;
  logic [REG_CNT-1:0] wr_sel;
  logic               rx_rdy, rx_ie, tx_rdy, tx_ie;
  logic [CHAR_W-1:0]  rx_byte;

  con_bus_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .bus_addr (bus_addr),
    .bus_rd   (bus_rd),
    .bus_wr   (bus_wr),
    .rd_sel   (rd_sel),
    .wr_sel   (wr_sel)
  );

  con_rx_unit #(.CHAR_W(CHAR_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (kbd_valid),
    .in_data  (kbd_data),
    .data_rd  (rd_sel[REG_RX_DATA]),
    .ctrl_wr  (wr_sel[REG_RX_CTRL]),
    .ie_wdata (bus_wdata[IE_BIT]),
    .rdy      (rx_rdy),
    .ie       (rx_ie),
    .held     (rx_byte),
    .irq      (irq_rx)
  );

  con_tx_unit #(.CHAR_W(CHAR_W), .BUSY_CYCLES(TX_BUSY_CYCLES)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_wr   (wr_sel[REG_TX_DATA]),
    .wdata     (bus_wdata[CHAR_W-1:0]),
    .ctrl_wr   (wr_sel[REG_TX_CTRL]),
    .ie_wdata  (bus_wdata[IE_BIT]),
    .rdy       (tx_rdy),
    .ie        (tx_ie),
    .out_valid (tx_valid),
    .out_data  (tx_data),
    .irq       (irq_tx)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_sel[REG_RX_CTRL]) begin
      bus_rdata[RDY_BIT] = rx_rdy;
      bus_rdata[IE_BIT]  = rx_ie;
    end else if (rd_sel[REG_RX_DATA]) begin
      bus_rdata[CHAR_W-1:0] = rx_byte;
    end else if (rd_sel[REG_TX_CTRL]) begin
      bus_rdata[RDY_BIT] = tx_rdy;
      bus_rdata[IE_BIT]  = tx_ie;
    end
  end
endmodule

// File: rtl/con_checker.sv
module con_checker #(
  parameter int unsigned ADDR_W         = 32,
  parameter int unsigned DATA_W         = 32,
  parameter int unsigned TX_BUSY_CYCLES = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              kbd_valid,
  input logic              tx_valid,
  input logic              irq_rx,
  input logic              irq_tx,
  input logic              rx_rdy,
  input logic              rx_ie,
  input logic              tx_rdy,
  input logic              tx_ie
);
  localparam logic [ADDR_W-1:0] RXD_ADDR = BASE_ADDR + ADDR_W'(4);
  localparam logic [ADDR_W-1:0] TXD_ADDR = BASE_ADDR + ADDR_W'(12);

  logic        rd_rxd, wr_txd;
  logic [31:0] busy_age;

  assign rd_rxd = bus_rd && (bus_addr == RXD_ADDR);
  assign wr_txd = bus_wr && (bus_addr == TXD_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n)                busy_age <= '0;
    else if (wr_txd && tx_rdy) busy_age <= 32'd1;
    else if (!tx_rdy)          busy_age <= busy_age + 32'd1;
  end

  AST_RX_SET: assert property (@(posedge clk) disable iff (!rst_n)
    kbd_valid |=> rx_rdy);                                       // R4
  AST_RX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rxd && !kbd_valid) |=> !rx_rdy);                         // R5
  AST_RX_ARRIVAL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rxd && kbd_valid) |=> rx_rdy);                           // R6
  AST_IRQ_RX: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |-> (rx_rdy && rx_ie));                               // R8
  AST_TX_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_txd && tx_rdy) |=> (tx_valid && !tx_rdy));               // R9
  AST_TX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |=> !tx_valid);                                     // R9
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_rdy && busy_age < TX_BUSY_CYCLES) |=> !tx_rdy);         // R10
  AST_TX_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_rdy && busy_age == TX_BUSY_CYCLES) |=> tx_rdy);         // R10
  AST_TX_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_txd && !tx_rdy) |=> !tx_valid);                          // R11
  AST_IRQ_TX: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tx |-> (tx_rdy && tx_ie));                               // R12
  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == '0));                              // R13
endmodule

bind mmio_console con_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .TX_BUSY_CYCLES(TX_BUSY_CYCLES), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_wr(bus_wr), .bus_rdata(bus_rdata), .kbd_valid(kbd_valid),
  .tx_valid(tx_valid), .irq_rx(irq_rx), .irq_tx(irq_tx),
  .rx_rdy(rx_rdy), .rx_ie(rx_ie), .tx_rdy(tx_rdy), .tx_ie(tx_ie)
);

// File: tb/test_mmio_console.sv
`timescale 1ns/1ps
module test_mmio_console;
  localparam int unsigned BUSY = 8;
  localparam logic [31:0] BASE = 32'hFFFF_0000;
  localparam logic [31:0] A_RXC = BASE + 32'h0;
  localparam logic [31:0] A_RXD = BASE + 32'h4;
  localparam logic [31:0] A_TXC = BASE + 32'h8;
  localparam logic [31:0] A_TXD = BASE + 32'hC;

  // {req[71:68], op[67:66] 0 idle/1 read/2 write/3 kbd, reg[65:64], wdata[63:32], expect[31:0]}
  localparam int NV = 17;
  localparam logic [71:0] VEC [0:NV-1] = '{
    {4'd1,  2'd1, 2'd0, 32'h0,        32'h0},   // R1 rx ctrl after reset
    {4'd1,  2'd1, 2'd2, 32'h0,        32'h1},   // R1 tx ctrl after reset
    {4'd13, 2'd0, 2'd0, 32'h0,        32'h0},   // R13 idle bus reads 0
    {4'd4,  2'd3, 2'd0, 32'h41,       32'h0},   // R4 arrival
    {4'd4,  2'd1, 2'd0, 32'h0,        32'h1},   // R4 ready set
    {4'd4,  2'd1, 2'd1, 32'h0,        32'h41},  // R4 byte, clears ready
    {4'd5,  2'd1, 2'd0, 32'h0,        32'h0},   // R5 ready cleared
    {4'd5,  2'd1, 2'd1, 32'h0,        32'h41},  // R5 byte kept
    {4'd3,  2'd2, 2'd0, 32'hFFFF_FFFF, 32'h0},  // R3 write all ones
    {4'd3,  2'd1, 2'd0, 32'h0,        32'h2},   // R3 only enable sticks
    {4'd7,  2'd2, 2'd1, 32'h55,       32'h0},   // R7 write rx data
    {4'd7,  2'd1, 2'd1, 32'h0,        32'h41},  // R7 byte unchanged
    {4'd6,  2'd3, 2'd0, 32'h7E,       32'h0},   // R6 arrival
    {4'd6,  2'd3, 2'd0, 32'h33,       32'h0},   // R6 overwrite
    {4'd6,  2'd1, 2'd0, 32'h0,        32'h3},   // R6 ready and enable
    {4'd6,  2'd1, 2'd1, 32'h0,        32'h33},  // R6 newest byte
    {4'd3,  2'd2, 2'd0, 32'h0,        32'h0}    // R3 disable again
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        kbd_valid = 1'b0;
  logic [7:0]  kbd_data = '0;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        irq_rx, irq_tx;

  int checks = 0;
  int errors = 0;
  bit ended = 1'b0;
  logic [31:0] seen;

  always #2.5 clk = ~clk;

  mmio_console #(.TX_BUSY_CYCLES(BUSY), .BASE_ADDR(BASE)) i_mmio_console (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .kbd_valid(kbd_valid), .kbd_data(kbd_data), .tx_valid(tx_valid),
    .tx_data(tx_data), .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // one bus cycle; seen = read data before the closing edge
  task automatic step(input logic rd, input logic wr, input logic [31:0] addr,
                      input logic [31:0] wd, input logic kv, input logic [7:0] kd);
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = addr; bus_wdata = wd;
    kbd_valid = kv; kbd_data = kd;
    #1 seen = bus_rdata;
    @(posedge clk);
    #1;
    bus_rd = 1'b0; bus_wr = 1'b0; kbd_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    check("R1 irq_rx", {31'd0, irq_rx}, 32'd0);
    check("R1 irq_tx", {31'd0, irq_tx}, 32'd0);
    check("R1 tx_valid", {31'd0, tx_valid}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [71:0] v;
      v = VEC[i];
      case (v[67:66])
        2'd0: step(1'b0, 1'b0, BASE + {28'd0, v[65:64], 2'b00}, 32'h0, 1'b0, 8'h0);
        2'd1: step(1'b1, 1'b0, BASE + {28'd0, v[65:64], 2'b00}, 32'h0, 1'b0, 8'h0);
        2'd2: step(1'b0, 1'b1, BASE + {28'd0, v[65:64], 2'b00}, v[63:32], 1'b0, 8'h0);
        default: step(1'b0, 1'b0, BASE, 32'h0, 1'b1, v[39:32]);
      endcase
      if (v[67:66] <= 2'd1)
        check($sformatf("R%0d vector %0d", v[71:68], i), seen, v[31:0]);
    end

    // R6 arrival and data read in the same cycle
    step(1'b1, 1'b0, A_RXD, 32'h0, 1'b1, 8'hC4);
    check("R6 read returns old byte", seen, 32'h33);
    step(1'b1, 1'b0, A_RXC, 32'h0, 1'b0, 8'h0);
    check("R6 ready stays set", seen, 32'h1);
    step(1'b1, 1'b0, A_RXD, 32'h0, 1'b0, 8'h0);
    check("R6 new byte stored", seen, 32'hC4);

    // R8 receive interrupt
    step(1'b0, 1'b1, A_RXC, 32'h2, 1'b0, 8'h0);
    check("R8 idle with ready clear", {31'd0, irq_rx}, 32'd0);
    step(1'b0, 1'b0, A_RXC, 32'h0, 1'b1, 8'h19);
    check("R8 raised on arrival", {31'd0, irq_rx}, 32'd1);
    step(1'b1, 1'b0, A_RXD, 32'h0, 1'b0, 8'h0);
    check("R8 dropped after read", {31'd0, irq_rx}, 32'd0);
    step(1'b0, 1'b1, A_RXC, 32'h0, 1'b0, 8'h0);
    step(1'b0, 1'b0, A_RXC, 32'h0, 1'b1, 8'h20);
    check("R8 masked when disabled", {31'd0, irq_rx}, 32'd0);

    // R2 addresses outside the map
    step(1'b0, 1'b1, BASE + 32'h10, 32'hFFFF_FFFF, 1'b0, 8'h0);
    check("R2 no tx pulse from stray write", {31'd0, tx_valid}, 32'd0);
    step(1'b0, 1'b1, BASE - 32'h4, 32'hFFFF_FFFF, 1'b0, 8'h0);
    step(1'b1, 1'b0, BASE + 32'h10, 32'h0, 1'b0, 8'h0);
    check("R2 stray read is zero", seen, 32'h0);
    step(1'b1, 1'b0, A_RXC, 32'h0, 1'b0, 8'h0);
    check("R2 rx ctrl untouched", seen, 32'h1);
    step(1'b1, 1'b0, A_TXC, 32'h0, 1'b0, 8'h0);
    check("R2 tx ctrl untouched", seen, 32'h1);

    // R3 ready bit is read-only on the transmit side
    step(1'b0, 1'b1, A_TXC, 32'h0, 1'b0, 8'h0);
    step(1'b1, 1'b0, A_TXC, 32'h0, 1'b0, 8'h0);
    check("R3 tx ready not writable", seen, 32'h1);

    // R12 transmit interrupt, R9 accept, R10 busy time
    step(1'b0, 1'b1, A_TXC, 32'h2, 1'b0, 8'h0);
    check("R12 raised when enabled and ready", {31'd0, irq_tx}, 32'd1);
    step(1'b0, 1'b1, A_TXD, 32'h1234_565A, 1'b0, 8'h0);
    check("R9 pulse", {31'd0, tx_valid}, 32'd1);
    check("R9 low byte", {24'd0, tx_data}, 32'h5A);
    check("R12 dropped while busy", {31'd0, irq_tx}, 32'd0);
    for (int k = 0; k < BUSY; k++) begin
      step(1'b1, 1'b0, A_TXC, 32'h0, 1'b0, 8'h0);
      check($sformatf("R10 busy read %0d", k), seen, 32'h2);
      check("R9 single pulse", {31'd0, tx_valid}, 32'd0);
    end
    step(1'b1, 1'b0, A_TXC, 32'h0, 1'b0, 8'h0);
    check("R10 ready returns", seen, 32'h3);
    check("R12 raised again", {31'd0, irq_tx}, 32'd1);

    // R11 write while busy is dropped and timing is kept
    step(1'b0, 1'b1, A_TXD, 32'h11, 1'b0, 8'h0);
    check("R11 first accepted", {31'd0, tx_valid}, 32'd1);
    step(1'b0, 1'b1, A_TXD, 32'h22, 1'b0, 8'h0);
    check("R11 busy write no pulse", {31'd0, tx_valid}, 32'd0);
    check("R11 data held", {24'd0, tx_data}, 32'h11);
    for (int k = 1; k < BUSY; k++) begin
      step(1'b1, 1'b0, A_TXC, 32'h0, 1'b0, 8'h0);
      check($sformatf("R11 still busy %0d", k), seen, 32'h2);
      check("R11 no late pulse", {31'd0, tx_valid}, 32'd0);
    end
    step(1'b1, 1'b0, A_TXC, 32'h0, 1'b0, 8'h0);
    check("R11 ready on original schedule", seen, 32'h3);

    step(1'b0, 1'b0, A_TXC, 32'h0, 1'b0, 8'h0);
    check("R13 idle rdata", bus_rdata, 32'h0);
    finish_run();
  end
endmodule